// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is the target side of a two-wire serial memory with a 64K-byte array addressed by 16 bits. It watches the clock and data lines of the bus and finds the START and STOP conditions. It accepts a control byte whose device code and chip-select bits match its own, and then serves reads from a synchronous memory port. Three kinds of read are served: a read at the current address, a random read, and a sequential stream. A random read begins with a dummy write that carries two address bytes and is followed by a repeated START. The data line is never driven high. The block only pulls it low, through an active-low drive output.

A single 16-bit address pointer is shared by every kind of read. The address phase of a dummy write loads it. It steps by one after each byte sent and wraps from FFFF to 0000. It keeps its value between transactions, so a current-address read continues from where the last transfer stopped. Both bus lines pass through two-flop synchronisers before any edge is detected. The memory port is a registered read with one cycle of latency, so it maps onto inferred block RAM.

Top module: `twi_mem_read_target`

## Requirements
- R1: A fall of SDA while SCL is high is a START and puts the block into the control-byte phase from any state, with SDA released. A rise of SDA while SCL is high is a STOP and ends the transaction.
- R2: The control byte is received MSB first. Bits 7..4 must equal the device code 1010, bits 3..1 must equal chip_sel[2:0], and bit 0 is the direction (1 = read, 0 = write). On a match the block pulls SDA low for the ninth clock as an ACK.
- R3: If the device code or the chip-select bits do not match, the block gives no ACK. It keeps SDA released for every clock until the next START.
- R4: A matching control byte with direction 1 is followed by the byte stored at the current pointer, sent MSB first.
- R5: A control byte with direction 0 is followed by the address high byte and then the address low byte. The block ACKs each of them and loads the pointer after the low byte. A repeated START and a read control byte then return the byte at the loaded address.
- R6: When the master ACKs a data byte, the block sends the byte at the next address with no new addressing.
- R7: The pointer resets to 0 and increases by one after each byte sent. It keeps its value across transactions, so a current-address read after a transfer that ended at address n returns the byte at n+1.
- R8: The pointer wraps from FFFF to 0000. A master ACK of the byte at FFFF yields the byte at 0000.
- R9: When the master NACKs a data byte, the block stops sending and leaves SDA released through the STOP that follows.
- R10: SDA is driven only by the active-low output sda_drive_n. Its value changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| chip_sel | input | 3 | Chip-select strap compared with bits 3..1 of the control byte |
| sda_drive_n | output | 1 | 0 pulls SDA low; 1 releases it |
| mem_addr | output | 16 | Read address to the memory array (the pointer) |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_addr |

## Verification
Two things can land on the same system cycle. One is the detection of a bus condition. The other is the bit engine's own work on that cycle: shifting a bit, or stepping the pointer. The pointer can also wrap on the same step that advances it. The bench cuts a control byte short after three bits and issues a repeated START. It then checks that the next full control byte is ACKed and that the byte returned shows the pointer was left untouched. It also streams across FFFF and checks that the byte after it comes from 0000. A monitor counts every change of sda_drive_n that happens while SCL is high.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + ADDR_W'(1);
  end

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> ptr == $past(ptr) + ADDR_W'(1));
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && ptr == '1) |=> ptr == '0);
  assert_ptr_load_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(load_val));
endmodule

// File: rtl/twi_rd_engine.sv
module twi_rd_engine
  import twi_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        chip_sel,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_load_val,
  output logic              ptr_inc,
  output logic              pull
);
  localparam int BIT_W = $clog2(BYTE_W);

  twi_state_t        state, ack_next;
  logic [BYTE_W-1:0] rx_sh, tx_sh, hi_q;
  logic [BIT_W-1:0]  bitn;
  logic              ack_half, master_ack;
  logic [BYTE_W-1:0] rx_byte;
  logic              id_ok, last_bit;

  assign rx_byte  = {rx_sh[BYTE_W-2:0], sda_lvl};
  assign id_ok    = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == chip_sel);
  assign last_bit = (bitn == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ack_next     <= ST_IDLE;
      rx_sh        <= '0;
      tx_sh        <= '0;
      hi_q         <= '0;
      bitn         <= '0;
      ack_half     <= 1'b0;
      master_ack   <= 1'b0;
      pull         <= 1'b0;
      ptr_load     <= 1'b0;
      ptr_load_val <= '0;
      ptr_inc      <= 1'b0;
    end else begin
      ptr_load <= 1'b0;
      ptr_inc  <= 1'b0;
      if (start_det) begin
        state    <= ST_CTRL;
        bitn     <= '0;
        pull     <= 1'b0;
        ack_half <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        pull     <= 1'b0;
        ack_half <= 1'b0;
      end else begin
        case (state)
          ST_CTRL, ST_AHI, ST_ALO: if (scl_rise) begin
            rx_sh <= rx_byte;
            bitn  <= bitn + BIT_W'(1);
            if (last_bit) begin
              state    <= ST_ACK;
              ack_half <= 1'b0;
              if (state == ST_CTRL) begin
                if (!id_ok) state <= ST_IDLE;
                ack_next <= rx_byte[0] ? ST_TX : ST_AHI;
              end else if (state == ST_AHI) begin
                hi_q     <= rx_byte;
                ack_next <= ST_ALO;
              end else begin
                ptr_load     <= 1'b1;
                ptr_load_val <= ADDR_W'({hi_q, rx_byte});
                ack_next     <= ST_IDLE;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_half) begin
              ack_half <= 1'b1;
              pull     <= 1'b1;
            end else begin
              ack_half <= 1'b0;
              state    <= ack_next;
              bitn     <= '0;
              if (ack_next == ST_TX) begin
                tx_sh <= mem_rdata;
                pull  <= ~mem_rdata[BYTE_W-1];
              end else begin
                pull  <= 1'b0;
              end
            end
          end
          ST_TX: if (scl_fall) begin
            bitn  <= bitn + BIT_W'(1);
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            if (last_bit) begin
              pull    <= 1'b0;
              state   <= ST_MACK;
              ptr_inc <= 1'b1;
            end else begin
              pull <= ~tx_sh[BYTE_W-2];
            end
          end
          ST_MACK: begin
            if (scl_rise) master_ack <= ~sda_lvl;
            if (scl_fall) begin
              if (master_ack) begin
                state <= ST_TX;
                bitn  <= '0;
                tx_sh <= mem_rdata;
                pull  <= ~mem_rdata[BYTE_W-1];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_IDLE: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> !scl_lvl);
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !pull);
  assert_mismatch_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CTRL && scl_rise && last_bit && !id_ok && !start_det && !stop_det)
      |=> state == ST_IDLE);
  assert_start_ctrl_R1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_CTRL && !pull));
  assert_nack_release_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MACK && scl_fall && !master_ack && !start_det && !stop_det)
      |=> (state == ST_IDLE && !pull));
endmodule

// File: rtl/twi_mem_read_target.sv
module twi_mem_read_target
  import twi_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        chip_sel,
  output logic              sda_drive_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc, pull;
  logic [ADDR_W-1:0] ptr_load_val, ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  twi_rd_engine #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_engine (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .chip_sel(chip_sel), .mem_rdata(mem_rdata),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc),
    .pull(pull)
  );

  twi_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(ptr)
  );

  assign sda_drive_n = ~pull;
  assign mem_addr    = ptr;
endmodule

// File: tb/tb_twi_mem_read_target.sv
module tb_twi_mem_read_target;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] chip_sel = 3'b101;
  logic sda_drive_n;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic sda_bus;
  int checks = 0;
  int errs = 0;
  int viol = 0;
  logic prev_scl = 1'b1;
  logic prev_dn = 1'b1;

  assign sda_bus = sda_m & sda_drive_n;
  always #5 clk = ~clk;

  twi_mem_read_target dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .chip_sel(chip_sel),
    .sda_drive_n(sda_drive_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= mem_f(mem_addr);

  always @(negedge clk) begin
    if (!rst && scl && prev_scl && sda_drive_n !== prev_dn) viol++;
    prev_scl <= scl;
    prev_dn  <= sda_drive_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1;   wait_h(H);
    sda_m = 1'b0; wait_h(H);
    scl = 1'b0;   wait_h(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H);
    scl = 1'b1;   wait_h(H);
    sda_m = 1'b1; wait_h(H);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; wait_h(H);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H / 2);
    b = sda_bus; wait_h(H / 2);
    scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(b);
    acked = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      v[i] = b;
    end
    write_bit(~mack);
  endtask

  task automatic set_addr(input logic [15:0] a, input string req);
    logic ack;
    bus_start();
    write_byte(8'hAA, ack); chk({req, " ctrl write ack"}, ack, 1);
    write_byte(a[15:8], ack); chk({req, " addr high ack"}, ack, 1);
    write_byte(a[7:0], ack);  chk({req, " addr low ack"}, ack, 1);
  endtask

  task automatic t_reset();
    chk("R10 reset released", sda_drive_n, 1);
    chk("R7 reset pointer", mem_addr, 16'h0000);
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    write_byte(8'hA9, ack); chk("R3 chip-select mismatch no ack", ack, 0);
    write_byte(8'h00, ack); chk("R3 ignored until START", ack, 0);
    chk("R3 SDA released", sda_drive_n, 1);
    bus_stop();
    bus_start();
    write_byte(8'h2B, ack); chk("R3 device code mismatch no ack", ack, 0);
    bus_stop();
  endtask

  task automatic t_current_read();
    logic ack;
    logic [7:0] d;
    bus_start();
    write_byte(8'hAB, ack); chk("R2 read control ack", ack, 1);
    read_byte(1'b0, d);     chk("R4 current address data", d, mem_f(16'h0000));
    chk("R9 released after NACK", sda_drive_n, 1);
    bus_stop();
    chk("R9 released after STOP", sda_drive_n, 1);
  endtask

  task automatic t_random_seq();
    logic ack;
    logic [7:0] d;
    set_addr(16'h1234, "R5");
    bus_start();
    write_byte(8'hAB, ack); chk("R5 read control ack", ack, 1);
    read_byte(1'b1, d); chk("R5 random read data", d, mem_f(16'h1234));
    read_byte(1'b1, d); chk("R6 sequential byte 2", d, mem_f(16'h1235));
    read_byte(1'b0, d); chk("R6 sequential byte 3", d, mem_f(16'h1236));
    bus_stop();
    bus_start();
    write_byte(8'hAB, ack);
    read_byte(1'b0, d); chk("R7 pointer kept across transactions", d, mem_f(16'h1237));
    bus_stop();
  endtask

  task automatic t_wrap();
    logic ack;
    logic [7:0] d;
    set_addr(16'hFFFE, "R8");
    bus_start();
    write_byte(8'hAB, ack);
    read_byte(1'b1, d); chk("R8 byte at FFFE", d, mem_f(16'hFFFE));
    read_byte(1'b1, d); chk("R8 byte at FFFF", d, mem_f(16'hFFFF));
    read_byte(1'b0, d); chk("R8 wrapped to 0000", d, mem_f(16'h0000));
    bus_stop();
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] d;
    bus_start();
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
    bus_start();
    write_byte(8'hAB, ack); chk("R1 repeated START restarts control phase", ack, 1);
    read_byte(1'b0, d); chk("R1 pointer untouched by abort", d, mem_f(16'h0001));
    bus_stop();
    chk("R1 STOP leaves SDA released", sda_drive_n, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_mismatch();
    t_current_read();
    t_random_seq();
    t_wrap();
    t_abort();
    chk("R10 no drive change while SCL high", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule